// File: doc/BRIEF.md
# Byte-Wide SPI Master with Register Bus

This peripheral drives one SPI slave and exchanges a single 8-bit frame each time software writes the transmit register. It sits on a simple 32-bit register bus with an address, a write strobe, a read strobe, write data and combinational read data. Software sets the serial clock rate, polarity and phase in a control word. It then asserts chip select by writing a register bit, loads a byte, polls a busy flag, and collects the received byte from the receive register.

The serial clock rate comes from two stages in series. The first stage is a fixed divider of 16 or 128, picked by one control bit. The second stage divides again by 2·(N+1), with N a 5-bit field. The clock line rests at the polarity level whenever no frame is running. Chip select is never driven by the engine. It is a register bit and always reflects what software last wrote.

Top module: `spi_byte_master`

## Requirements
- R1: After reset the control, status, transmit, receive and auxiliary registers read 0, the chip-select register reads 0x40, cs_n is 1 and sclk is 0. Register offsets: control 0x00, status 0x04, chip select 0x08, transmit 0x0C, receive 0x10, auxiliary 0x14.
- R2: cs_n equals bit 6 of the last value written to the chip-select register, so 0x21 asserts it (low) and 0x61 releases it.
- R3: Writing the transmit register while idle starts a frame of exactly 8 sclk periods (16 sclk transitions). Status bit 0 reads 1 from the cycle after the write until the frame ends.
- R4: mosi carries bits 7:0 of the written byte, most significant first, and holds each bit stable across the slave's sampling edge.
- R5: The low 8 bits of the receive register return the byte shifted in from miso, MSB first. Control bit 7 is CPHA and bit 6 is CPOL, and all four combinations work. CPHA=0 samples on the leading edge; CPHA=1 samples on the trailing edge.
- R6: While no frame is active, sclk equals control bit 6.
- R7: One sclk half period lasts D·(N+1) clock cycles, where D is 128 if control bit 5 is set and 16 otherwise, and N is control bits 4:0.
- R8: Status bit 2 (receive full) sets when a frame ends. It clears on a read of the receive register, or on a status write with bit 2 at 0. If a frame ends in the same cycle as a clearing access, the flag stays set.
- R9: A transmit-register write during a frame is ignored: the frame in progress and its byte are unaffected and no further frame starts.
- R10: The auxiliary register at 0x14 stores and returns all 32 written bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 5 | Byte offset of the register accessed |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (side effects on the receive register) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to the slave |
| miso | input | 1 | Serial data from the slave |
| cs_n | output | 1 | Chip select, active low |

## Verification
Two events can land on the same cycle: the frame-completion update that sets the receive-full flag, and a receive-register read that clears it. The bench provokes the collision by holding a read of the receive register on every cycle of a frame, releasing it only once busy is seen low. The last held read therefore coincides with completion. After that, the flag must still read 1 and the receive register must hold the new byte. A mode-aware slave model drives miso and samples mosi on its own edges, which judges data order and phase in all four modes.

// File: rtl/spi_byte_pkg.sv
package spi_byte_pkg;

    // register offsets (byte addresses)
    localparam logic [7:0] OFS_CTRL = 8'h00;
    localparam logic [7:0] OFS_STAT = 8'h04;
    localparam logic [7:0] OFS_CSEL = 8'h08;
    localparam logic [7:0] OFS_TXB  = 8'h0C;
    localparam logic [7:0] OFS_RXB  = 8'h10;
    localparam logic [7:0] OFS_AUX  = 8'h14;

    // bit positions
    localparam int STAT_BUSY = 0;
    localparam int STAT_RXF  = 2;
    localparam int CSEL_PIN  = 6;

    localparam logic [7:0] CSEL_RESET = 8'h40;

    // control word layout: bit7 phase, bit6 polarity, bit5 slow prescale, 4:0 divider
    typedef struct packed {
        logic       cpha;
        logic       cpol;
        logic       slow;
        logic [4:0] ndiv;
    } clk_cfg_t;

    // edge index counts sclk transitions 0..2*BITS-1; even = leading, odd = trailing
    function automatic logic edge_samples(input logic cpha, input logic idx_lsb);
        return idx_lsb == cpha;
    endfunction

    function automatic logic edge_shifts(input logic cpha, input logic idx_lsb,
                                         input logic idx_zero);
        return cpha ? (!idx_lsb && !idx_zero) : idx_lsb;
    endfunction

endpackage

// File: rtl/spi_byte_clkdiv.sv
module spi_byte_clkdiv #(
    parameter int FIRST_LO = 16,
    parameter int FIRST_HI = 128,
    parameter int N_W      = 5
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           run,
    input  logic           slow,
    input  logic [N_W-1:0] ndiv,
    output logic           half_tick
);
    localparam int PRE_W = (FIRST_HI > FIRST_LO) ? $clog2(FIRST_HI) : $clog2(FIRST_LO);

    logic [PRE_W-1:0] pre_q;
    logic [PRE_W-1:0] pre_lim;
    logic [N_W-1:0]   sec_q;
    logic             pre_wrap;

    assign pre_lim  = slow ? PRE_W'(FIRST_HI - 1) : PRE_W'(FIRST_LO - 1);
    assign pre_wrap = run && (pre_q == pre_lim);
    assign half_tick = pre_wrap && (sec_q == ndiv);   // R7

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            pre_q <= '0;
        end else if (pre_wrap) begin
            pre_q <= '0;
        end else begin
            pre_q <= pre_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            sec_q <= '0;
        end else if (pre_wrap) begin
            sec_q <= (sec_q == ndiv) ? '0 : sec_q + 1'b1;
        end
    end

endmodule

// File: rtl/spi_byte_shifter.sv
module spi_byte_shifter
    import spi_byte_pkg::*;
#(
    parameter int BITS = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            start,
    input  logic [BITS-1:0] tx_byte,
    input  logic            cpha,
    input  logic            half_tick,
    input  logic            miso,
    output logic            busy,
    output logic            phase,
    output logic            mosi,
    output logic            done,
    output logic [BITS-1:0] rx_byte
);
    localparam int EDGES = 2 * BITS;
    localparam int IDX_W = $clog2(EDGES);

    logic [BITS-1:0]  sh_q;
    logic [BITS-1:0]  rx_q;
    logic [IDX_W-1:0] idx_q;
    logic             last_edge;
    logic             do_sample;
    logic             do_shift;

    assign last_edge = busy && !done && half_tick && (idx_q == IDX_W'(EDGES - 1));
    assign do_sample = edge_samples(cpha, idx_q[0]);
    assign do_shift  = edge_shifts(cpha, idx_q[0], idx_q == '0);
    assign mosi      = sh_q[BITS-1];   // R4: MSB first
    assign rx_byte   = rx_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy  <= 1'b0;
            phase <= 1'b0;
            done  <= 1'b0;
            idx_q <= '0;
            sh_q  <= '0;
            rx_q  <= '0;
        end else begin
            done <= last_edge;
            if (!busy) begin
                if (start) begin          // R3
                    busy  <= 1'b1;
                    sh_q  <= tx_byte;
                    idx_q <= '0;
                    phase <= 1'b0;
                end
            end else if (done) begin
                busy <= 1'b0;             // leaves with phase back at 0
            end else if (half_tick) begin
                phase <= ~phase;
                idx_q <= idx_q + 1'b1;
                if (do_sample) begin
                    rx_q <= {rx_q[BITS-2:0], miso};   // R5
                end
                if (do_shift) begin
                    sh_q <= {sh_q[BITS-2:0], 1'b0};
                end
            end
        end
    end

endmodule

// File: rtl/spi_byte_master.sv
module spi_byte_master
    import spi_byte_pkg::*;
#(
    parameter int ADDR_W   = 5,
    parameter int DATA_W   = 32,
    parameter int FIRST_LO = 16,
    parameter int FIRST_HI = 128
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              sclk,
    output logic              mosi,
    input  logic              miso,
    output logic              cs_n
);
    localparam int BITS = 8;
    localparam int N_W  = 5;

    clk_cfg_t          cfg_q;
    logic [7:0]        csel_q;
    logic [BITS-1:0]   txb_q;
    logic [BITS-1:0]   rxb_q;
    logic              rxfull_q;
    logic [DATA_W-1:0] aux_q;

    logic hit_ctrl, hit_stat, hit_csel, hit_txb, hit_rxb, hit_aux;
    logic start, busy, phase, done, half_tick;
    logic [BITS-1:0] rx_byte;

    assign hit_ctrl = bus_addr == ADDR_W'(OFS_CTRL);
    assign hit_stat = bus_addr == ADDR_W'(OFS_STAT);
    assign hit_csel = bus_addr == ADDR_W'(OFS_CSEL);
    assign hit_txb  = bus_addr == ADDR_W'(OFS_TXB);
    assign hit_rxb  = bus_addr == ADDR_W'(OFS_RXB);
    assign hit_aux  = bus_addr == ADDR_W'(OFS_AUX);

    assign start = bus_wr && hit_txb && !busy;   // R9: ignored while busy

    spi_byte_clkdiv #(
        .FIRST_LO (FIRST_LO),
        .FIRST_HI (FIRST_HI),
        .N_W      (N_W)
    ) u_div (
        .clk       (clk),
        .rst       (rst),
        .run       (busy),
        .slow      (cfg_q.slow),
        .ndiv      (cfg_q.ndiv),
        .half_tick (half_tick)
    );

    spi_byte_shifter #(
        .BITS (BITS)
    ) u_shift (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .tx_byte   (bus_wdata[BITS-1:0]),
        .cpha      (cfg_q.cpha),
        .half_tick (half_tick),
        .miso      (miso),
        .busy      (busy),
        .phase     (phase),
        .mosi      (mosi),
        .done      (done),
        .rx_byte   (rx_byte)
    );

    always_ff @(posedge clk) begin
        if (rst) begin                      // R1
            cfg_q    <= '0;
            csel_q   <= CSEL_RESET;
            txb_q    <= '0;
            rxb_q    <= '0;
            rxfull_q <= 1'b0;
            aux_q    <= '0;
        end else begin
            if (bus_wr && hit_ctrl) cfg_q  <= clk_cfg_t'(bus_wdata[7:0]);
            if (bus_wr && hit_csel) csel_q <= bus_wdata[7:0];
            if (bus_wr && hit_aux)  aux_q  <= bus_wdata;    // R10
            if (start)              txb_q  <= bus_wdata[BITS-1:0];
            // R8: completion wins over a clearing access in the same cycle
            if (done) begin
                rxb_q    <= rx_byte;
                rxfull_q <= 1'b1;
            end else if ((bus_rd && hit_rxb) ||
                         (bus_wr && hit_stat && !bus_wdata[STAT_RXF])) begin
                rxfull_q <= 1'b0;
            end
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (hit_ctrl)      bus_rdata[7:0]     = cfg_q;
        else if (hit_stat) begin
            bus_rdata[STAT_BUSY] = busy;
            bus_rdata[STAT_RXF]  = rxfull_q;
        end
        else if (hit_csel) bus_rdata[7:0]     = csel_q;
        else if (hit_txb)  bus_rdata[BITS-1:0] = txb_q;
        else if (hit_rxb)  bus_rdata[BITS-1:0] = rxb_q;
        else if (hit_aux)  bus_rdata          = aux_q;
    end

    assign sclk = cfg_q.cpol ^ phase;   // R6
    assign cs_n = csel_q[CSEL_PIN];     // R2

endmodule

// File: rtl/spi_byte_master_chk.sv
module spi_byte_master_chk
    import spi_byte_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              sclk,
    input logic              cs_n,
    input logic              busy,
    input logic              cpol,
    input logic              rxfull,
    input logic [7:0]        txb
);
    a_r2_cs_follows_write: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == ADDR_W'(OFS_CSEL)) |=> (cs_n == $past(bus_wdata[CSEL_PIN])));

    a_r3_write_starts_frame: assert property (@(posedge clk) disable iff (rst)
        (!busy && bus_wr && bus_addr == ADDR_W'(OFS_TXB)) |=> busy);

    a_r6_idle_level: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (sclk == cpol));

    a_r8_full_at_end: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> rxfull);

    a_r9_busy_write_ignored: assert property (@(posedge clk) disable iff (rst)
        (busy && bus_wr && bus_addr == ADDR_W'(OFS_TXB)) |=> $stable(txb));

endmodule

bind spi_byte_master spi_byte_master_chk #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .sclk      (sclk),
    .cs_n      (cs_n),
    .busy      (busy),
    .cpol      (cfg_q.cpol),
    .rxfull    (rxfull_q),
    .txb       (txb_q)
);

// File: tb/spi_byte_master_bench.sv
module spi_byte_master_bench;
    import spi_byte_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [4:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        sclk, mosi, cs_n;
    logic        s_miso = 1'b0;

    int errors = 0;
    int checks = 0;

    always #5 clk = ~clk;

    spi_byte_master u_spi_byte_master (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .sclk      (sclk),
        .mosi      (mosi),
        .miso      (s_miso),
        .cs_n      (cs_n)
    );

    // mode-aware slave model
    bit         m_cpol = 1'b0;
    bit         m_cpha = 1'b0;
    logic [7:0] s_tx = '0;
    logic [7:0] s_rx = '0;
    int         s_edges = 0;
    time        t1 = 0;
    time        t2 = 0;

    always @(sclk) begin
        if (!rst && cs_n === 1'b0) begin
            s_edges++;
            if (s_edges == 1) t1 = $time;
            if (s_edges == 2) t2 = $time;
            if (sclk !== m_cpol) begin          // leading edge
                if (!m_cpha) s_rx = {s_rx[6:0], mosi};
                else begin
                    s_miso = s_tx[7];
                    s_tx   = {s_tx[6:0], 1'b0};
                end
            end else begin                      // trailing edge
                if (!m_cpha) begin
                    s_tx   = {s_tx[6:0], 1'b0};
                    s_miso = s_tx[7];
                end else s_rx = {s_rx[6:0], mosi};
            end
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr  = a[4:0];
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a[4:0];
        bus_rd   = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd   = 1'b0;
    endtask

    function automatic int half_cycles(input logic [7:0] cfg);
        return (cfg[5] ? 128 : 16) * (int'(cfg[4:0]) + 1);
    endfunction

    task automatic prep(input logic [7:0] cfg, input logic [7:0] stx);
        wr(OFS_CSEL, 32'h61);
        m_cpha = cfg[7];
        m_cpol = cfg[6];
        wr(OFS_CTRL, {24'h0, cfg});
        s_tx = stx; s_miso = stx[7]; s_rx = '0; s_edges = 0;
        wr(OFS_CSEL, 32'h21);
        chk("R2 cs asserted", {31'h0, cs_n}, 32'h0);
    endtask

    task automatic wait_idle(output logic [31:0] st);
        int guard = 0;
        st = 32'h1;
        while (st[0] && guard < 20000) begin
            rd(OFS_STAT, st);
            guard++;
        end
    endtask

    task automatic xfer(input logic [7:0] cfg, input logic [7:0] mtx, input logic [7:0] stx);
        logic [31:0] st, d;
        prep(cfg, stx);
        wr(OFS_TXB, {24'h0, mtx});
        rd(OFS_STAT, st);
        chk("R3 busy after write", {31'h0, st[0]}, 32'h1);
        wait_idle(st);
        chk("R8 rxfull at end", {31'h0, st[2]}, 32'h1);
        chk("R6 idle sclk", {31'h0, sclk}, {31'h0, cfg[6]});
        chk("R3 edge count", s_edges, 16);
        chk("R4 mosi byte", {24'h0, s_rx}, {24'h0, mtx});
        chk("R7 half period", 32'((t2 - t1) / 10), half_cycles(cfg));
        rd(OFS_RXB, d);
        chk("R5 rx byte", d, {24'h0, stx});
        rd(OFS_STAT, st);
        chk("R8 clear on rx read", {31'h0, st[2]}, 32'h0);
        wr(OFS_CSEL, 32'h61);
        chk("R2 cs released", {31'h0, cs_n}, 32'h1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=hung expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [31:0] d, st;
        void'($urandom(32'h5eed_0042));
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd(OFS_CTRL, d); chk("R1 ctrl", d, 32'h0);
        rd(OFS_STAT, d); chk("R1 status", d, 32'h0);
        rd(OFS_CSEL, d); chk("R1 csel", d, 32'h40);
        rd(OFS_TXB, d);  chk("R1 txb", d, 32'h0);
        rd(OFS_RXB, d);  chk("R1 rxb", d, 32'h0);
        rd(OFS_AUX, d);  chk("R1 aux", d, 32'h0);
        chk("R1 cs_n", {31'h0, cs_n}, 32'h1);
        chk("R1 sclk", {31'h0, sclk}, 32'h0);

        // R10 auxiliary store
        wr(OFS_AUX, 32'hA5C3_0F71);
        rd(OFS_AUX, d); chk("R10 aux", d, 32'hA5C3_0F71);

        // R5 directed: all four modes at several dividers
        for (int m = 0; m < 4; m++) begin
            xfer({m[1:0], 1'b0, 5'd0}, 8'hA5, 8'h3C);
            xfer({m[1:0], 1'b0, 5'd2}, 8'h81, 8'h7E);
        end
        // R7 slow first divider
        xfer(8'h21, 8'h5A, 8'hC3);
        xfer(8'hE0, 8'hFF, 8'h00);

        // random traffic
        for (int i = 0; i < 12; i++) begin
            logic [7:0] cfg;
            cfg = {2'($urandom()), 1'b0, 5'($urandom() % 4)};
            xfer(cfg, 8'($urandom()), 8'($urandom()));
        end

        // R6 idle level follows polarity written while idle
        wr(OFS_CTRL, 32'h40);
        chk("R6 idle high", {31'h0, sclk}, 32'h1);
        wr(OFS_CTRL, 32'h00);
        chk("R6 idle low", {31'h0, sclk}, 32'h0);

        // R9 write during a frame is ignored
        prep(8'h00, 8'h96);
        wr(OFS_TXB, 32'h0000_00C1);
        wr(OFS_TXB, 32'h0000_0018);
        rd(OFS_TXB, d); chk("R9 txb kept", d, 32'hC1);
        wait_idle(st);
        repeat (40) @(negedge clk);
        rd(OFS_STAT, st); chk("R9 no second frame", {31'h0, st[0]}, 32'h0);
        chk("R9 edges", s_edges, 16);
        chk("R9 mosi byte", {24'h0, s_rx}, 32'hC1);
        rd(OFS_RXB, d); chk("R9 rx byte", d, 32'h96);

        // R8 status write clears; write with bit2 set leaves it
        xfer(8'h01, 8'h12, 8'h34);
        prep(8'h00, 8'h55);
        wr(OFS_TXB, 32'h0000_00AA);
        wait_idle(st);
        wr(OFS_STAT, 32'h4);
        rd(OFS_STAT, st); chk("R8 bit2 write keeps", {31'h0, st[2]}, 32'h1);
        wr(OFS_STAT, 32'h0);
        rd(OFS_STAT, st); chk("R8 status write clears", {31'h0, st[2]}, 32'h0);

        // R8 collision: rx read held through completion cycle
        prep(8'h80, 8'hE7);
        wr(OFS_TXB, 32'h0000_0042);
        @(negedge clk);
        bus_addr = OFS_RXB[4:0];
        bus_rd   = 1'b1;
        begin
            int guard = 0;
            while (u_spi_byte_master.bus_rdata !== 32'hE7 && guard < 20000) begin
                @(negedge clk);
                guard++;
            end
        end
        // completion edge has passed with bus_rd high
        bus_rd = 1'b0;
        rd(OFS_STAT, st);
        chk("R8 set wins over read", {31'h0, st[2]}, 32'h1);
        chk("R8 busy low", {31'h0, st[0]}, 32'h0);
        rd(OFS_RXB, d); chk("R8 new byte", d, 32'hE7);
        rd(OFS_STAT, st); chk("R8 cleared after", {31'h0, st[2]}, 32'h0);
        wr(OFS_CSEL, 32'h61);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule